// File: doc/BRIEF.md
# Auto-Reload Interval Timer

A 16-bit down-counting interval timer reached through an 8-bit register bus. Software keeps a 16-bit reload value in a pair of latch bytes, picks one-shot or continuous operation in a mode register, and starts a count by writing the upper counter byte. Each time the count runs through zero the timer raises an expiry flag. In continuous mode the counter then refills itself from the latch pair and keeps running, which gives a fixed period.

Software acknowledges an expiry by reading the lower counter byte. It masks the interrupt output with a single enable bit. The counter moves one step on each prescale strobe, and the strobe fires once every `PRESCALE` clock cycles.

Top module: `ivtimer8`

## Requirements
- R1: After reset the latches, counter, mode register (offset 11), flag register (offset 13) and enable register (offset 14) all read 0x00, and `irq_o` is low.
- R2: A write to offset 4 or offset 6 loads the low latch byte, and a write to offset 7 loads the high latch byte. Offsets 6 and 7 read back the latch bytes. None of these writes changes the running counter.
- R3: A write to offset 5 copies the data into the high latch and loads the counter with {data, low latch}. It clears the expiry flag, restarts the prescaler and starts a new count. Offset 4 reads counter bits 7:0 and offset 5 reads counter bits 15:8.
- R4: The counter decrements by one on every PRESCALE-th clock after a start, and holds its value between strobes.
- R5: On a strobe that finds the counter at zero the counter goes to 0xFFFF. If the flag is armed, that strobe also sets the expiry flag, which reads as bit 6 (0x40) of offset 13.
- R6: When bit 6 of the mode register is 1 (continuous, for example 0x40), the strobe after an expiry loads the counter from the latch pair. The flag is set on every expiry, so a latch value N gives a period of (N+2)·PRESCALE clocks. A latch change takes effect at the next reload.
- R7: When mode bit 6 is 0 (one-shot), the counter does not reload: it continues down from 0xFFFF. The flag is set only once per start.
- R8: A read of offset 4 clears the expiry flag at the clock edge that ends the read. If an expiry falls on that same edge, the flag is set.
- R9: Bit 6 of offset 14 is the interrupt enable. Offset 13 bit 7 and `irq_o` both equal flag AND enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Register index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_o | output | 1 | Enabled expiry interrupt |

## Verification
The embedded assertions check on every cycle the local rules of the block:
- the counter holds between strobes;
- a start loads {data, low latch} and clears the flag;
- latch writes leave the count alone;
- a reload takes the previous latch value;
- a one-shot expiry goes to 0xFFFF without reloading;
- an acknowledge clears the flag unless an expiry lands on the same edge.

Only the bench scenarios can show whole-period behaviour. These include the exact (N+2)·PRESCALE period, a latch change appearing only at the next reload, the flag firing once in one-shot mode, and the enable bit gating `irq_o`.

// File: rtl/ivtimer8.sv
module ivtimer8 #(
  parameter int PRESCALE = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [AW-1:0] A_CLO  = AW'(4);
  localparam logic [AW-1:0] A_CHI  = AW'(5);
  localparam logic [AW-1:0] A_LLO  = AW'(6);
  localparam logic [AW-1:0] A_LHI  = AW'(7);
  localparam logic [AW-1:0] A_MODE = AW'(11);
  localparam logic [AW-1:0] A_FLAG = AW'(13);
  localparam logic [AW-1:0] A_ENAB = AW'(14);

  logic [PW-1:0] pre_q;
  logic [15:0]   cnt_q;
  logic [7:0]    lat_lo, lat_hi, mode_q;
  logic          en_q, flag_q, armed_q, reload_q;

  wire tick   = (pre_q == PW'(PRESCALE - 1));
  wire start  = wr_en && (addr == A_CHI);
  wire ack    = rd_en && (addr == A_CLO);
  wire cont   = mode_q[6];
  wire expire = tick && !start && !reload_q && (cnt_q == 16'h0000);
  wire raise  = expire && (cont || armed_q);

  assign irq_o = flag_q && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= '0;
      cnt_q    <= '0;
      lat_lo   <= '0;
      lat_hi   <= '0;
      mode_q   <= '0;
      en_q     <= 1'b0;
      flag_q   <= 1'b0;
      armed_q  <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      pre_q <= (start || tick) ? '0 : pre_q + 1'b1;

      if (wr_en) begin
        case (addr)
          A_CLO, A_LLO:  lat_lo <= wdata;
          A_CHI, A_LHI:  lat_hi <= wdata;
          A_MODE:        mode_q <= wdata;
          A_ENAB:        en_q   <= wdata[6];
          default: ;
        endcase
      end

      if (start) begin
        cnt_q    <= {wdata, lat_lo};
        armed_q  <= 1'b1;
        reload_q <= 1'b0;
      end else if (tick) begin
        if (reload_q) begin
          cnt_q    <= {lat_hi, lat_lo};
          reload_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 16'd1;
          if (cnt_q == 16'h0000) begin
            reload_q <= cont;
            armed_q  <= 1'b0;
          end
        end
      end

      if (start)      flag_q <= 1'b0;
      else if (raise) flag_q <= 1'b1;
      else if (ack)   flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_CLO:   rdata = cnt_q[7:0];
      A_CHI:   rdata = cnt_q[15:8];
      A_LLO:   rdata = lat_lo;
      A_LHI:   rdata = lat_hi;
      A_MODE:  rdata = mode_q;
      A_FLAG:  rdata = {irq_o, flag_q, 6'b0};
      A_ENAB:  rdata = {1'b0, en_q, 6'b0};
      default: rdata = 8'h00;
    endcase
  end

  // R4: counter only moves on a strobe or a start
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !start |=> $stable(cnt_q));

  // R3: start loads counter from data and low latch, clears flag
  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == {$past(wdata), $past(lat_lo)}) && !flag_q);

  // R2: latch-only writes leave the count alone
  a_r2_latch_no_disturb: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == A_LLO || addr == A_LHI) && !tick |=> cnt_q == $past(cnt_q));

  // R6: reload takes the latch pair as it stood before the edge
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tick && reload_q && !start |=> cnt_q == $past({lat_hi, lat_lo}));

  // R7: one-shot expiry wraps without scheduling a reload
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !cont |=> (cnt_q == 16'hFFFF) && !reload_q);

  // R8: acknowledge clears unless an expiry lands on the same edge
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !raise && !start |=> !flag_q);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    raise |=> flag_q);

  // R5: flag only rises on a strobe edge
  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));
endmodule

// File: tb/ivtimer8_tb_top.sv
module ivtimer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_o;

  int nchk = 0, nfail = 0, edge_n = 0, s = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] adr_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) edge_n <= edge_n + 1;

  ivtimer8 #(.PRESCALE(4), .AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  // monitor: compares each read against the scoreboard head
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      logic [3:0] a;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = adr_q.pop_front();
      nchk++;
      if (rdata !== e) begin
        nfail++;
        $display("FAIL %s addr %0d: got %02h expected %02h", t, a, rdata, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t); adr_q.push_back(a);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic start(input logic [7:0] d);
    wr(4'd5, d);
    s = edge_n;
  endtask

  task automatic wait_to(input int t);
    while (edge_n - s < t) begin @(posedge clk); #1; end
  endtask

  task automatic chk_irq(input logic e, input string t);
    nchk++;
    if (irq_o !== e) begin
      nfail++;
      $display("FAIL %s irq_o: got %0b expected %0b", t, irq_o, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd(4'd11, 8'h00, "R1 mode");
    rd(4'd13, 8'h00, "R1 flags");
    rd(4'd6,  8'h00, "R1 latch lo");
    rd(4'd14, 8'h00, "R1 enable");
    chk_irq(1'b0, "R1");

    // continuous, latch 5, enabled
    wr(4'd6, 8'h05);
    wr(4'd7, 8'h00);
    wr(4'd11, 8'h40);
    wr(4'd14, 8'h40);
    rd(4'd14, 8'h40, "R9 enable readback");
    start(8'h00);
    wait_to(10); rd(4'd4, 8'h03, "R4 two strobes");
    wait_to(20); rd(4'd13, 8'h00, "R5 no flag at zero");
    wait_to(23); rd(4'd4, 8'h00, "R8 ack on expiry edge");
    rd(4'd13, 8'hC0, "R8 set wins");
    chk_irq(1'b1, "R9 irq enabled");
    wait_to(26); rd(4'd5, 8'hFF, "R5 wrap to FFFF");
    wait_to(29); rd(4'd5, 8'h00, "R6 reload hi");
    rd(4'd4, 8'h05, "R6 reload lo");
    rd(4'd13, 8'h00, "R8 ack cleared");
    wait_to(53); rd(4'd13, 8'hC0, "R6 second expiry at period");
    wait_to(60); wr(4'd6, 8'h20);
    rd(4'd4, 8'h04, "R2 latch write no disturb");
    rd(4'd7, 8'h00, "R2 latch hi");
    rd(4'd6, 8'h20, "R2 latch lo");
    wait_to(85); rd(4'd4, 8'h20, "R6 new latch at reload");
    rd(4'd5, 8'h00, "R6 new latch hi");
    wait_to(217); rd(4'd13, 8'hC0, "R6 expiry of new period");
    start(8'h00);
    rd(4'd13, 8'h00, "R3 start clears flag");
    rd(4'd4, 8'h20, "R3 counter from latch");

    // one-shot, interrupt masked
    wr(4'd11, 8'h00);
    wr(4'd14, 8'h00);
    wr(4'd6, 8'h02);
    start(8'h01);
    rd(4'd7, 8'h01, "R3 hi byte into latch");
    rd(4'd5, 8'h01, "R3 counter hi");
    rd(4'd4, 8'h02, "R3 counter lo");
    start(8'h00);
    wait_to(13); rd(4'd13, 8'h40, "R9 masked flag");
    chk_irq(1'b0, "R9 irq masked");
    rd(4'd4, 8'hFF, "R7 wrap no reload");
    wait_to(17); rd(4'd4, 8'hFE, "R7 keeps decrementing");
    rd(4'd5, 8'hFF, "R7 hi byte");
    wait_to(30); rd(4'd13, 8'h00, "R7 flag once per start");

    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule